// File: doc/BRIEF.md
# Virtual-Channel Link Multiplexer

This block carries several virtual channels over one physical link between two network-on-chip routers. On the sending side every channel has its own flit input with a valid/ready handshake and its own two-entry queue. A round-robin arbiter picks one channel per cycle. The chosen flit goes onto the shared link together with a channel index. On the receiving side the index steers the flit into that channel's own two-entry buffer. Each receive buffer has its own valid/ready consumer port.

A channel is eligible only when its sending queue holds a flit and its receive buffer has room. A consumer that stalls on one channel therefore holds back only that channel. The other channels keep the link. Every buffer derives its ready from registered occupancy, so readiness never passes combinationally from one stage to the one before it. Two entries per buffer are enough to keep a single channel moving at one flit per cycle.

Top module: `vc_link_mux`

## Requirements
- R1: After reset every queue is empty. All `in_ready_o` bits are 1, all `out_valid_o` bits are 0, and `link_valid_o` is 0.
- R2: A flit accepted on channel v at clock edge k is on the link during the cycle after edge k, with `link_vc_o` = v (binary channel index). It appears on `out_valid_o[v]` and slice v of `out_flit_o` after edge k+1.
- R3: A single channel with a ready consumer passes flits in order at one flit per cycle. Its `in_ready_o` does not drop, and consecutive flits leave on consecutive cycles.
- R4: Each queue and each receive buffer holds two flits. With the consumer stalled, a channel accepts exactly four flits before its `in_ready_o` goes to 0. All four flits are later delivered in order.
- R5: While two channels both have flits and room, link grants alternate between them on consecutive cycles.
- R6: A channel whose receive buffer is full is never granted the link. Flits of other channels still pass through.
- R7: After reset the round-robin pointer is at channel 0. When both channels become eligible in the same first cycle, channel 0 is granted first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NUM_VC | Per-channel flit valid, sending side |
| in_ready_o | output | NUM_VC | Per-channel queue ready |
| in_flit_i | input | NUM_VC*FLIT_W | Per-channel flit data, channel v in slice v |
| link_valid_o | output | 1 | A flit is on the shared link this cycle |
| link_vc_o | output | ceil(log2(NUM_VC)) | Channel index of the link flit |
| link_flit_o | output | FLIT_W | Flit on the shared link |
| out_valid_o | output | NUM_VC | Per-channel receive buffer valid |
| out_ready_i | input | NUM_VC | Per-channel consumer ready |
| out_flit_o | output | NUM_VC*FLIT_W | Per-channel head flit, channel v in slice v |

## Verification
The buffer assertions assume that each producer raises `in_valid_i` and each consumer raises `out_ready_i` only according to the handshake, so a push never meets a full buffer and a pop never meets an empty one. The starvation check assumes that a requesting channel keeps requesting until it is served. The bench drives inputs one time unit after the rising edge and holds each flit until a sampled ready shows it was taken. The tests cover single flits, sustained streams, a stalled consumer and two competing channels, and every flit is matched against the sequence that was sent.

// File: rtl/vc_link_pkg.sv
package vc_link_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vc_fifo2.sv
module vc_fifo2 #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         ready_o,
  input  logic         pop_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0] mem_q [2];
  logic         wr_q, rd_q;
  logic [1:0]   cnt_q;

  // ready from registered occupancy only
  assign ready_o = cnt_q < 2'd2;
  assign valid_o = cnt_q != 2'd0;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= 2'd0;
    end else begin
      if (push_i) wr_q <= ~wr_q;
      if (pop_i)  rd_q <= ~rd_q;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 2'd1;
        2'b01:   cnt_q <= cnt_q - 2'd1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> cnt_q != 2'd2);
  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != 2'd0);
  // R3
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/vc_rr_arb.sv
module vc_rr_arb #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] gnt_idx_o
);
  logic [IW-1:0] ptr_q;
  logic          found;
  int unsigned   cand;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    cand      = 0;
    for (int k = 0; k < N; k++) begin
      cand = (int'(ptr_q) + k) % N;
      if (!found && req_i[cand]) begin
        found           = 1'b1;
        gnt_o[cand]     = 1'b1;
        gnt_idx_o       = IW'(cand);
      end
    end
  end

  // pointer moves to the channel after the one served
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (found) ptr_q <= (int'(gnt_idx_o) == N - 1) ? '0 : gnt_idx_o + IW'(1);
  end

  // R5
  onehot_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6
  gnt_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);

  for (genvar g = 0; g < N; g++) begin : g_wait
    logic [IW:0] wait_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) wait_q <= '0;
      else if (req_i[g] && !gnt_o[g]) wait_q <= wait_q + 1'b1;
      else wait_q <= '0;
    end
    // R5
    starve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(wait_q) < N);
  end
endmodule

// File: rtl/vc_link_mux.sv
module vc_link_mux #(
  parameter int NUM_VC = 2,
  parameter int FLIT_W = 32,
  localparam int IW    = vc_link_pkg::idx_w(NUM_VC)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_VC-1:0]        in_valid_i,
  output logic [NUM_VC-1:0]        in_ready_o,
  input  logic [NUM_VC*FLIT_W-1:0] in_flit_i,
  output logic                     link_valid_o,
  output logic [IW-1:0]            link_vc_o,
  output logic [FLIT_W-1:0]        link_flit_o,
  output logic [NUM_VC-1:0]        out_valid_o,
  input  logic [NUM_VC-1:0]        out_ready_i,
  output logic [NUM_VC*FLIT_W-1:0] out_flit_o
);
  logic [NUM_VC-1:0] up_rdy, up_vld, dn_rdy, dn_push, req, gnt;
  logic [FLIT_W-1:0] up_data [NUM_VC];

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    vc_fifo2 #(.W(FLIT_W)) u_up (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (in_valid_i[v] & up_rdy[v]),
      .data_i  (in_flit_i[v*FLIT_W +: FLIT_W]),
      .ready_o (up_rdy[v]),
      .pop_i   (gnt[v]),
      .valid_o (up_vld[v]),
      .data_o  (up_data[v])
    );

    // eligible: flit waiting and room at the far side
    assign req[v]     = up_vld[v] & dn_rdy[v];
    assign dn_push[v] = link_valid_o && (int'(link_vc_o) == v);

    vc_fifo2 #(.W(FLIT_W)) u_dn (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (dn_push[v]),
      .data_i  (link_flit_o),
      .ready_o (dn_rdy[v]),
      .pop_i   (out_valid_o[v] & out_ready_i[v]),
      .valid_o (out_valid_o[v]),
      .data_o  (out_flit_o[v*FLIT_W +: FLIT_W])
    );
  end

  assign in_ready_o = up_rdy;

  vc_rr_arb #(.N(NUM_VC), .IW(IW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .gnt_o     (gnt),
    .gnt_idx_o (link_vc_o)
  );

  assign link_valid_o = |gnt;
  assign link_flit_o  = up_data[link_vc_o];

  // R6
  link_room_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> dn_rdy[link_vc_o]);
  // R2
  link_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o |-> up_vld[link_vc_o]);
endmodule

// File: tb/vc_link_mux_bench.sv
`timescale 1ns/1ps
module vc_link_mux_bench;
  localparam int N = 2;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0]   in_valid = '0, out_ready = '0;
  logic [N-1:0]   in_ready, out_valid;
  logic [N*W-1:0] in_flit = '0, out_flit;
  logic           link_valid;
  logic [0:0]     link_vc;
  logic [W-1:0]   link_flit;

  int n_tests = 0, n_fail = 0, cyc = 0, stalls = 0;
  logic [W-1:0] got0[$], got1[$];
  int cyc0[$], lvc[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vc_link_mux u_vc_link_mux (
    .clk_i(clk), .rst_ni(rst_ni),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_flit_i(in_flit),
    .link_valid_o(link_valid), .link_vc_o(link_vc), .link_flit_o(link_flit),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_flit_o(out_flit)
  );

  always @(negedge clk) begin
    if (rst_ni) begin
      if (out_valid[0] && out_ready[0]) begin
        got0.push_back(out_flit[W-1:0]);
        cyc0.push_back(cyc);
      end
      if (out_valid[1] && out_ready[1]) got1.push_back(out_flit[2*W-1:W]);
      if (link_valid) lvc.push_back(int'(link_vc));
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    got0.delete(); got1.delete(); cyc0.delete(); lvc.delete();
  endtask

  task automatic send(int v, int n, logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      in_valid[v] = 1'b1;
      in_flit[v*W +: W] = base + W'(i);
      @(negedge clk);
      while (!in_ready[v]) begin
        stalls++;
        @(negedge clk);
      end
      @(posedge clk); #1;
    end
    in_valid[v] = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; in_valid = '0; out_ready = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1", "in_ready", 64'(in_ready), 64'(2'b11));
    check("R1", "out_valid", 64'(out_valid), 64'(0));
    check("R1", "link_valid", 64'(link_valid), 64'(0));
  endtask

  task automatic t_single();
    @(posedge clk); #1;
    clear_mon(); out_ready = 2'b11;
    in_valid[1] = 1'b1; in_flit[W +: W] = 32'h1111_0001;
    @(negedge clk);
    check("R2", "in_ready vc1", 64'(in_ready[1]), 64'(1));
    @(posedge clk); #1 in_valid[1] = 1'b0;
    @(negedge clk);
    check("R2", "link_valid", 64'(link_valid), 64'(1));
    check("R2", "link_vc", 64'(link_vc), 64'(1));
    check("R2", "link_flit", 64'(link_flit), 64'(32'h1111_0001));
    check("R2", "out_valid early", 64'(out_valid[1]), 64'(0));
    @(negedge clk);
    check("R2", "out_valid", 64'(out_valid[1]), 64'(1));
    check("R2", "out_flit", 64'(out_flit[W +: W]), 64'(32'h1111_0001));
    @(negedge clk);
    check("R2", "out_valid after pop", 64'(out_valid[1]), 64'(0));
    check("R2", "delivered count", 64'(got1.size()), 64'(1));
  endtask

  task automatic t_stream();
    @(posedge clk); #1;
    clear_mon(); out_ready = 2'b11; stalls = 0;
    send(0, 8, 32'h0A00_0000);
    repeat (5) @(negedge clk);
    check("R3", "stalls", 64'(stalls), 64'(0));
    check("R3", "count", 64'(got0.size()), 64'(8));
    if (got0.size() == 8) begin
      for (int i = 0; i < 8; i++)
        check("R3", "order", 64'(got0[i]), 64'(32'h0A00_0000 + i));
      check("R3", "span", 64'(cyc0[7] - cyc0[0]), 64'(7));
    end
  endtask

  task automatic t_block();
    @(posedge clk); #1;
    clear_mon(); out_ready = 2'b00;
    send(0, 4, 32'h0B00_0000);
    @(negedge clk);
    check("R4", "vc0 ready full", 64'(in_ready[0]), 64'(0));
    check("R4", "vc1 ready", 64'(in_ready[1]), 64'(1));
    check("R6", "link idle", 64'(link_valid), 64'(0));
    check("R4", "head", 64'(out_flit[W-1:0]), 64'(32'h0B00_0000));
    @(posedge clk); #1 out_ready[1] = 1'b1;
    send(1, 3, 32'h1B00_0000);
    repeat (4) @(negedge clk);
    check("R6", "vc1 count", 64'(got1.size()), 64'(3));
    if (got1.size() == 3)
      for (int i = 0; i < 3; i++)
        check("R6", "vc1 order", 64'(got1[i]), 64'(32'h1B00_0000 + i));
    check("R6", "vc0 still blocked", 64'(in_ready[0]), 64'(0));
    @(posedge clk); #1 out_ready[0] = 1'b1;
    repeat (8) @(negedge clk);
    check("R4", "vc0 count", 64'(got0.size()), 64'(4));
    if (got0.size() == 4)
      for (int i = 0; i < 4; i++)
        check("R4", "vc0 order", 64'(got0[i]), 64'(32'h0B00_0000 + i));
  endtask

  task automatic t_rr();
    int bad;
    do_reset();
    clear_mon(); out_ready = 2'b11;
    fork
      send(0, 6, 32'h0C00_0000);
      send(1, 6, 32'h1C00_0000);
    join
    repeat (6) @(negedge clk);
    check("R7", "first grant", 64'(lvc.size() > 0 ? lvc[0] : -1), 64'(0));
    bad = 0;
    for (int i = 1; i < 10 && i < lvc.size(); i++)
      if (lvc[i] == lvc[i-1]) bad++;
    check("R5", "alternation breaks", 64'(bad), 64'(0));
    check("R5", "link count", 64'(lvc.size()), 64'(12));
    check("R5", "vc0 count", 64'(got0.size()), 64'(6));
    check("R5", "vc1 count", 64'(got1.size()), 64'(6));
    if (got0.size() == 6 && got1.size() == 6)
      for (int i = 0; i < 6; i++) begin
        check("R5", "vc0 order", 64'(got0[i]), 64'(32'h0C00_0000 + i));
        check("R5", "vc1 order", 64'(got1[i]), 64'(32'h1C00_0000 + i));
      end
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_stream();
    t_block();
    t_rr();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule